// File: doc/BRIEF.md
# Pixel Event Buffer with Four-Phase Address-Event Output

This block sits between an event-camera deserialiser and a spiking consumer. Each incoming pixel event carries a pixel address, an ON/OFF polarity bit and a timestamp. It arrives on a valid/ready stream. The block packs the event into one storage word and queues it in a synchronous first-in first-out buffer. It then offers the queued events one at a time on a four-phase request/acknowledge handshake. Occupancy and a sticky overflow flag are reported continuously.

A three-state handshake machine drives the output side. The head word is read into a holding register when a request starts, so the presented fields cannot move while the consumer is mid-handshake. The entry is removed from the buffer when the consumer acknowledges it. Parameters set the address width, the timestamp width, whether a polarity bit is stored (ON-only sensors drop it) and the buffer depth. The depth must be a power of two, and elaboration rejects any other value.

Top module: `evt_aer_bridge`

## Requirements
- R1: A stored word holds the address in its top field, the polarity bit directly below it and the timestamp in the lowest bits. With the default 16-bit address and 32-bit timestamp, these are bits [48:33], [32] and [31:0]. Events leave in the order they were accepted, with every field unchanged.
- R2: `in_ready` is high exactly when `occ` is below DEPTH. An event is accepted on a clock edge where `in_valid` and `in_ready` are both high. When `in_ready` is low, `in_valid` adds nothing to the buffer.
- R3: While `rst` is high, the handshake is idle, `occ` is 0, `out_req` and `ovf` are 0, and `in_ready` is 1.
- R4: The handshake goes from idle to request on an edge where `occ` is at least 1. It goes from request to wait on an edge where `out_ack` is high. It goes from wait back to idle on an edge where `out_ack` is low.
- R5: `out_req` is high only in the request state. `out_addr`, `out_pol` and `out_ts` stay constant from the cycle `out_req` rises until the handshake returns to idle.
- R6: The head entry is removed, and `occ` drops by one, on the request-to-wait edge. Each acknowledged event is removed exactly once.
- R7: `ovf` becomes 1 after any edge where `in_valid` is high while `occ` equals DEPTH. Once set, it stays 1 until `rst`.
- R8: When an accept and a removal fall on the same edge, `occ` is unchanged.
- R9: With HAS_POL = 0, no polarity bit is stored, `in_pol` is ignored and `out_pol` always reads 1 (ON).
- R10: An event accepted into an empty buffer with the handshake idle raises `out_req` after the second rising edge that follows the accept edge. The first of those edges is the accept edge itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | Upstream event present |
| in_ready | output | 1 | Buffer has room |
| in_addr | input | ADDR_W | Pixel address of incoming event |
| in_pol | input | 1 | Polarity of incoming event (1 = ON) |
| in_ts | input | TS_W | Timestamp of incoming event |
| out_req | output | 1 | Handshake request |
| out_ack | input | 1 | Handshake acknowledge from consumer |
| out_addr | output | ADDR_W | Address of event on offer |
| out_pol | output | 1 | Polarity of event on offer |
| out_ts | output | TS_W | Timestamp of event on offer |
| occ | output | log2(DEPTH)+1 | Number of events held |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is a completely full buffer that has the head event already on offer. To get there, `out_ack` is held low while valid input keeps arriving. The stalled handshake then lets `occ` climb all the way to DEPTH, and further input sets the overflow flag. From there the bench drains to a small occupancy. It steers the handshake into the request state and applies an acknowledge and a new event on the same edge, which exercises the balanced push-and-pop case. A second instance with depth 4 and no polarity bit reaches the full boundary within a few cycles and shows the forced ON polarity.

// File: rtl/evt_aer_pkg.sv
package evt_aer_pkg;

   typedef enum logic [1:0] {
      HS_IDLE = 2'b00,
      HS_REQ  = 2'b01,
      HS_WAIT = 2'b10
   } hs_state_e;

   function automatic int unsigned evt_word_w(input int unsigned aw,
                                              input int unsigned tw,
                                              input bit has_pol);
      return aw + tw + (has_pol ? 1 : 0);
   endfunction

endpackage

// File: rtl/evt_pack.sv
module evt_pack #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned TS_W    = 32,
   parameter bit          HAS_POL = 1'b1,
   localparam int unsigned WORD_W = evt_aer_pkg::evt_word_w(ADDR_W, TS_W, HAS_POL)
) (
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              ev_pol,
   input  logic [TS_W-1:0]   ev_ts,
   output logic [WORD_W-1:0] ev_word,
   input  logic [WORD_W-1:0] hd_word,
   output logic [ADDR_W-1:0] hd_addr,
   output logic              hd_pol,
   output logic [TS_W-1:0]   hd_ts
);

   assign hd_addr = hd_word[WORD_W-1 -: ADDR_W];
   assign hd_ts   = hd_word[TS_W-1:0];

   generate
      if (HAS_POL) begin : g_pol
         assign ev_word = {ev_addr, ev_pol, ev_ts};
         assign hd_pol  = hd_word[TS_W];
      end else begin : g_on_only
         logic unused_pol;
         assign unused_pol = ev_pol;
         assign ev_word    = {ev_addr, ev_ts};
         assign hd_pol     = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
   parameter int unsigned WORD_W = 49,
   parameter int unsigned DEPTH  = 128,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_try,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_pop,
   output logic [WORD_W-1:0] rd_data,
   output logic [CNT_W-1:0]  occ,
   output logic              full,
   output logic              ovf
);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic [CNT_W-1:0]  count;
   logic              wr_en;

   assign full    = (count == CNT_W'(DEPTH));
   assign wr_en   = wr_try && !full;
   assign occ     = count;
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
         if (rd_pop) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_en, rd_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (wr_try && full) ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/evt_hs_fsm.sv
module evt_hs_fsm (
   input  logic clk,
   input  logic rst,
   input  logic has_data,
   input  logic ack,
   output logic req,
   output logic load,
   output logic pop
);
   import evt_aer_pkg::*;

   hs_state_e state;
   hs_state_e state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         HS_IDLE: if (has_data) state_nx = HS_REQ;
         HS_REQ:  if (ack)      state_nx = HS_WAIT;
         HS_WAIT: if (!ack)     state_nx = HS_IDLE;
         default:               state_nx = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) state <= HS_IDLE;
      else     state <= state_nx;
   end

   assign req  = (state == HS_REQ);
   assign load = (state == HS_IDLE) && has_data;
   assign pop  = (state == HS_REQ) && ack;

endmodule

// File: rtl/evt_aer_bridge.sv
module evt_aer_bridge #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned TS_W    = 32,
   parameter bit          HAS_POL = 1'b1,
   parameter int unsigned DEPTH   = 128,
   localparam int unsigned PTR_W  = $clog2(DEPTH),
   localparam int unsigned CNT_W  = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_pol,
   input  logic [TS_W-1:0]   in_ts,
   output logic              out_req,
   input  logic              out_ack,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_pol,
   output logic [TS_W-1:0]   out_ts,
   output logic [CNT_W-1:0]  occ,
   output logic              ovf
);

   localparam int unsigned WORD_W = evt_aer_pkg::evt_word_w(ADDR_W, TS_W, HAS_POL);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("evt_aer_bridge: DEPTH must be a power of two, at least 2");
      end
      if (ADDR_W == 0 || TS_W == 0) begin : g_bad_width
         $error("evt_aer_bridge: ADDR_W and TS_W must be non-zero");
      end
   endgenerate

   logic [WORD_W-1:0] ev_word;
   logic [WORD_W-1:0] head_word;
   logic [WORD_W-1:0] hold_word;
   logic              fifo_full;
   logic              hs_load;
   logic              hs_pop;

   evt_pack #(.ADDR_W(ADDR_W), .TS_W(TS_W), .HAS_POL(HAS_POL)) pack_i (
      .ev_addr (in_addr),
      .ev_pol  (in_pol),
      .ev_ts   (in_ts),
      .ev_word (ev_word),
      .hd_word (hold_word),
      .hd_addr (out_addr),
      .hd_pol  (out_pol),
      .hd_ts   (out_ts)
   );

   evt_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) fifo_i (
      .clk     (clk),
      .rst     (rst),
      .wr_try  (in_valid),
      .wr_data (ev_word),
      .rd_pop  (hs_pop),
      .rd_data (head_word),
      .occ     (occ),
      .full    (fifo_full),
      .ovf     (ovf)
   );

   evt_hs_fsm hs_i (
      .clk      (clk),
      .rst      (rst),
      .has_data (occ != '0),
      .ack      (out_ack),
      .req      (out_req),
      .load     (hs_load),
      .pop      (hs_pop)
   );

   assign in_ready = !fifo_full;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)          hold_word <= '0;
      else if (hs_load) hold_word <= head_word;
   end

endmodule

// File: rtl/evt_aer_bridge_chk.sv
module evt_aer_bridge_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned TS_W   = 32,
   parameter int unsigned DEPTH  = 128,
   parameter int unsigned CNT_W  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_req,
   input logic              out_ack,
   input logic [ADDR_W-1:0] out_addr,
   input logic              out_pol,
   input logic [TS_W-1:0]   out_ts,
   input logic [CNT_W-1:0]  occ,
   input logic              ovf
);

   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (occ == CNT_W'(DEPTH)) |-> !in_ready); // R2

   AST_ROOM_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
      (occ < CNT_W'(DEPTH)) |-> in_ready); // R2

   AST_REQ_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
      out_req |-> (occ != '0)); // R4

   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
      (out_req && out_ack) |=> !out_req); // R4

   AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
      (out_req && !out_ack) |=> (out_req && $stable(out_addr) && $stable(out_pol) && $stable(out_ts))); // R5

   AST_POP_ONCE: assert property (@(posedge clk) disable iff (rst)
      (out_req && out_ack && !(in_valid && in_ready)) |=> (occ == $past(occ) - 1'b1)); // R6

   AST_BALANCED: assert property (@(posedge clk) disable iff (rst)
      (out_req && out_ack && in_valid && in_ready) |=> (occ == $past(occ))); // R8

   AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_ready) |=> ovf); // R7

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf); // R7

endmodule

bind evt_aer_bridge evt_aer_bridge_chk #(
   .ADDR_W (ADDR_W),
   .TS_W   (TS_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_req  (out_req),
   .out_ack  (out_ack),
   .out_addr (out_addr),
   .out_pol  (out_pol),
   .out_ts   (out_ts),
   .occ      (occ),
   .ovf      (ovf)
);

// File: tb/evt_aer_bridge_tb.sv
`timescale 1ns/1ps
module evt_aer_bridge_tb_top;

   localparam int M_DEPTH = 128;
   localparam int S_DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_addr = '0;
   logic        in_pol = 1'b0;
   logic [31:0] in_ts = '0;
   logic        out_ack = 1'b0;
   logic        ack_s = 1'b0;

   logic        in_ready, out_req, out_pol, ovf;
   logic [15:0] out_addr;
   logic [31:0] out_ts;
   logic [7:0]  occ;

   logic        s_ready, s_req, s_pol, s_ovf;
   logic [15:0] s_addr;
   logic [31:0] s_ts;
   logic [2:0]  s_occ;

   always #4 clk = ~clk;

   evt_aer_bridge dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .in_pol(in_pol), .in_ts(in_ts),
      .out_req(out_req), .out_ack(out_ack), .out_addr(out_addr),
      .out_pol(out_pol), .out_ts(out_ts), .occ(occ), .ovf(ovf)
   );

   evt_aer_bridge #(.HAS_POL(1'b0), .DEPTH(S_DEPTH)) dut_small (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(s_ready),
      .in_addr(in_addr), .in_pol(in_pol), .in_ts(in_ts),
      .out_req(s_req), .out_ack(ack_s), .out_addr(s_addr),
      .out_pol(s_pol), .out_ts(s_ts), .occ(s_occ), .ovf(s_ovf)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference model state: 0 idle, 1 request, 2 wait
   int          m_state = 0;
   logic [48:0] q[$];
   logic [48:0] m_head = '0;
   bit          m_ovf = 1'b0;

   function automatic logic [48:0] pack_ev(input logic [15:0] a, input logic p, input logic [31:0] t);
      return {a, p, t};
   endfunction

   task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk_eq("R2 in_ready", 64'(in_ready), 64'(q.size() < M_DEPTH));
      chk_eq("R5 out_req", 64'(out_req), 64'(m_state == 1));
      chk_eq("R6/R8 occupancy", 64'(occ), 64'(q.size()));
      chk_eq("R7 overflow", 64'(ovf), 64'(m_ovf));
      if (m_state == 1) begin
         chk_eq("R1 address", 64'(out_addr), 64'(m_head[48:33]));
         chk_eq("R1 polarity", 64'(out_pol), 64'(m_head[32]));
         chk_eq("R1 timestamp", 64'(out_ts), 64'(m_head[31:0]));
      end
   endtask

   task automatic step(input logic v, input logic [15:0] a, input logic p,
                       input logic [31:0] t, input logic k);
      bit can_push;
      can_push = (q.size() < M_DEPTH);
      in_valid = v; in_addr = a; in_pol = p; in_ts = t; out_ack = k;
      if (v && !can_push) m_ovf = 1'b1;
      case (m_state)
         0: if (q.size() > 0) begin m_state = 1; m_head = q[0]; end
         1: if (k) begin m_state = 2; void'(q.pop_front()); end
         2: if (!k) m_state = 0;
         default: m_state = 0;
      endcase
      if (v && can_push) q.push_back(pack_ev(a, p, t));
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic rstep(input int vperc, input bit fast);
      logic k;
      logic v;
      v = (($urandom % 100) < vperc);
      case (m_state)
         1:       k = fast ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
         2:       k = (($urandom % 3) != 0);
         default: k = 1'b0;
      endcase
      step(v, 16'($urandom), 1'($urandom), $urandom, k);
   endtask

   task automatic do_reset();
      rst = 1'b1; in_valid = 1'b0; out_ack = 1'b0; ack_s = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_eq("R3 reset in_ready", 64'(in_ready), 64'd1);
      chk_eq("R3 reset out_req", 64'(out_req), 64'd0);
      chk_eq("R3 reset occupancy", 64'(occ), 64'd0);
      chk_eq("R3 R7 reset clears overflow", 64'(ovf), 64'd0);
      chk_eq("R3 reset small occupancy", 64'(s_occ), 64'd0);
      chk_eq("R3 reset small overflow", 64'(s_ovf), 64'd0);
      q.delete(); m_state = 0; m_ovf = 1'b0; m_head = '0;
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R4: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int start_occ;
      void'($urandom(32'h00C0FFEE));
      @(negedge clk);
      do_reset();

      // R10 latency and R9 forced ON polarity
      step(1'b1, 16'h1234, 1'b0, 32'hCAFE0001, 1'b0);
      chk_eq("R10 no request on accept edge", 64'(out_req), 64'd0);
      chk_eq("R10 small no request yet", 64'(s_req), 64'd0);
      step(1'b0, 16'h0, 1'b0, 32'h0, 1'b0);
      chk_eq("R10 request after second edge", 64'(out_req), 64'd1);
      chk_eq("R10 small request", 64'(s_req), 64'd1);
      chk_eq("R9 small polarity forced ON", 64'(s_pol), 64'd1);
      chk_eq("R9 small address", 64'(s_addr), 64'h1234);
      chk_eq("R1 main polarity kept OFF", 64'(out_pol), 64'd0);
      ack_s = 1'b1;
      step(1'b0, 16'h0, 1'b1, 32'h0, 1'b1);
      chk_eq("R4 small request drops on ack", 64'(s_req), 64'd0);
      ack_s = 1'b0;
      step(1'b0, 16'h0, 1'b1, 32'h0, 1'b0);
      chk_eq("R6 small empty after ack", 64'(s_occ), 64'd0);

      // R2 small full boundary with ack held low
      for (int i = 0; i < 5; i++) step(1'b1, 16'(16'h100 + i), 1'b0, 32'(i), 1'b0);
      chk_eq("R2 small occupancy at depth", 64'(s_occ), 64'(S_DEPTH));
      chk_eq("R2 small in_ready low when full", 64'(s_ready), 64'd0);
      chk_eq("R7 small overflow set", 64'(s_ovf), 64'd1);
      chk_eq("R9 small head polarity ON", 64'(s_pol), 64'd1);

      // random traffic, responsive consumer
      for (int i = 0; i < 3000; i++) rstep(50, 1'b1);

      // fill to full with the handshake stalled
      while (q.size() < M_DEPTH) step(1'b1, 16'($urandom), 1'($urandom), $urandom, 1'b0);
      for (int i = 0; i < 3; i++) step(1'b1, 16'($urandom), 1'($urandom), $urandom, 1'b0);
      chk_eq("R2 in_ready low at depth", 64'(in_ready), 64'd0);
      chk_eq("R2 occupancy held at depth", 64'(occ), 64'(M_DEPTH));
      chk_eq("R7 overflow after push while full", 64'(ovf), 64'd1);

      // R8 balanced push and pop
      while (q.size() > 10) rstep(0, 1'b1);
      while (m_state != 1) step(1'b0, 16'h0, 1'b0, 32'h0, 1'b0);
      start_occ = q.size();
      step(1'b1, 16'hBEEF, 1'b1, 32'h5A5A5A5A, 1'b1);
      chk_eq("R8 occupancy unchanged on push with pop", 64'(occ), 64'(start_occ));

      // drain and confirm sticky overflow
      while (q.size() > 0 || m_state != 0) rstep(0, 1'b1);
      chk_eq("R7 overflow sticky after drain", 64'(ovf), 64'd1);
      chk_eq("R6 empty after drain", 64'(occ), 64'd0);

      // heavy input, slow consumer
      for (int i = 0; i < 3000; i++) rstep(80, 1'b0);

      do_reset();
      chk_eq("R7 only reset clears overflow", 64'(ovf), 64'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule